// File: doc/BRIEF.md
# Register-Mapped SCCB Master Bridge

This block lets a host program an image sensor over a two-wire SCCB bus through a small byte-wide register file. The host first stores an enable value and the sensor's 8-bit write-form slave address. It then loads an index byte, plus a data byte for writes, and starts a transfer by writing an operation code. It polls a status register until that register holds a completion code. Read results are left in a dedicated result register.

A register write is sent as one three-phase SCCB transaction. A register read is sent as a two-phase write that sets the sensor's index, followed by a two-phase read of one byte. The master does not acknowledge that byte. SCL is produced from the system clock by a parameterised quarter-period divider. SDA is open-drain: the block either pulls the line low or releases it.

Top module: `sccb_bridge`

## Requirements
- R1: Host registers sit at these byte offsets: 0 operation, 1 status, 2 enable, 3 slave address, 4 write index, 5 write data, 8 read index, 9 read data. Offsets 2, 3, 4, 5 and 8 read back the last value written. Offset 0 reads 0x00. Host writes to offsets 1 and 9 have no effect. Unmapped offsets read 0x00.
- R2: Writing 0x05 to offset 0 while enable is usable produces this bus sequence: START, the slave address with bit 0 cleared, the write index, the write data, STOP. Each byte is sent MSB first and is followed by a ninth clock during which the master releases SDA.
- R3: Writing 0x70 to offset 0 while enable is usable produces this bus sequence: START, the address with bit 0 cleared, the read index, STOP, START, the address with bit 0 set, eight bits sampled MSB first, a ninth clock with SDA released (NACK), STOP. The sampled byte appears at offset 9.
- R4: Status reads 0x00 from the cycle after an accepted operation until completion. After that it reads 0x04 for a finished write and 0x01 for a finished read.
- R5: If enable holds 0x00 or 0x01, writing any operation code sets status to 0xFF and causes no bus activity.
- R6: Any operation code other than 0x05 or 0x70 sets status to 0xFF and causes no bus activity.
- R7: An operation code written while a transfer is in progress is ignored. The running transfer, its bus sequence and its final status are unchanged.
- R8: Address, index and data are captured when a transfer starts. Host writes to those registers during the transfer do not change the bytes on the bus.
- R9: Each SCL period lasts 4*QTR_CYCLES clocks. SDA changes while SCL is high only to form START (falling edge) or STOP (rising edge).
- R10: After reset every register reads 0x00, and SCL is high with SDA released. Both lines stay released whenever no transfer runs.
- R11: The read-data register changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Register byte offset |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for host_addr (combinational) |
| scl_o | output | 1 | SCCB clock |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The hardest situations to reach from the ports need something to happen inside the busy window of a running transaction. One is an operation code arriving mid-transfer. Another is a host rewrite of the address, index or data registers while the engine is still shifting bytes out.

The bench reaches both by issuing host writes a fixed number of cycles after the start command, well inside the several hundred cycles a transfer lasts. It then compares every START, STOP and byte seen on the wire against the queue of items predicted before the edits were made.

A behavioural slave on the open-drain line drives the read byte from its own memory. This makes the sampled path and the NACK clock observable, and lets the bench check written bytes by reading them back.

// File: rtl/sccb_pkg.sv
package sccb_pkg;

  localparam int SEG_W = 4;

  localparam logic [3:0] OFS_OP     = 4'd0;
  localparam logic [3:0] OFS_STATUS = 4'd1;
  localparam logic [3:0] OFS_ENABLE = 4'd2;
  localparam logic [3:0] OFS_SADDR  = 4'd3;
  localparam logic [3:0] OFS_WIDX   = 4'd4;
  localparam logic [3:0] OFS_WDAT   = 4'd5;
  localparam logic [3:0] OFS_RIDX   = 4'd8;
  localparam logic [3:0] OFS_RDAT   = 4'd9;

  localparam logic [7:0] CODE_WRITE = 8'h05;
  localparam logic [7:0] CODE_READ  = 8'h70;

  localparam logic [7:0] ST_BUSY    = 8'h00;
  localparam logic [7:0] ST_WR_DONE = 8'h04;
  localparam logic [7:0] ST_RD_DONE = 8'h01;
  localparam logic [7:0] ST_REJECT  = 8'hFF;

  typedef enum logic [2:0] {
    K_START = 3'd0,
    K_TX    = 3'd1,
    K_RX    = 3'd2,
    K_STOP  = 3'd3,
    K_END   = 3'd4
  } seg_kind_e;

  typedef enum logic [1:0] {
    SRC_AW  = 2'd0,
    SRC_AR  = 2'd1,
    SRC_IDX = 2'd2,
    SRC_DAT = 2'd3
  } byte_src_e;

  // Enable values 0x00 and 0x01 keep the bus closed.
  function automatic logic bus_usable(input logic [7:0] en);
    return en[7:1] != 7'd0;
  endfunction

  function automatic logic [7:0] addr_wr_form(input logic [7:0] a);
    return {a[7:1], 1'b0};
  endfunction

  function automatic logic [7:0] addr_rd_form(input logic [7:0] a);
    return {a[7:1], 1'b1};
  endfunction

  // Segment plan of one transaction.
  function automatic seg_kind_e plan_kind(input logic is_rd, input logic [SEG_W-1:0] seg);
    seg_kind_e k;
    if (!is_rd) begin
      case (seg)
        4'd0:             k = K_START;
        4'd1, 4'd2, 4'd3: k = K_TX;
        4'd4:             k = K_STOP;
        default:          k = K_END;
      endcase
    end else begin
      case (seg)
        4'd0, 4'd4:       k = K_START;
        4'd1, 4'd2, 4'd5: k = K_TX;
        4'd3, 4'd7:       k = K_STOP;
        4'd6:             k = K_RX;
        default:          k = K_END;
      endcase
    end
    return k;
  endfunction

  function automatic byte_src_e plan_src(input logic is_rd, input logic [SEG_W-1:0] seg);
    byte_src_e s;
    s = SRC_AW;
    if (seg == 4'd2) s = SRC_IDX;
    else if (!is_rd && seg == 4'd3) s = SRC_DAT;
    else if (is_rd && seg == 4'd5) s = SRC_AR;
    return s;
  endfunction

  // Line levels for one quarter of a segment: {scl, sda_released, condition_phase}.
  function automatic logic [2:0] line_next(input seg_kind_e k, input logic [1:0] q,
                                           input logic prev_sda, input logic tx_bit);
    logic scl;
    logic sda;
    logic cnd;
    scl = 1'b1;
    sda = 1'b1;
    cnd = 1'b0;
    case (k)
      K_START: begin
        sda = (q < 2'd2);
        cnd = 1'b1;
      end
      K_TX: begin
        scl = q[1];
        sda = (q == 2'd0) ? prev_sda : tx_bit;
      end
      K_RX: begin
        scl = q[1];
        sda = (q == 2'd0) ? prev_sda : 1'b1;
      end
      K_STOP: begin
        scl = q[1];
        sda = (q == 2'd0) ? prev_sda : (q == 2'd3);
        cnd = 1'b1;
      end
      default: ;
    endcase
    return {scl, sda, cnd};
  endfunction

endpackage

// File: rtl/sccb_quarter_tick.sv
module sccb_quarter_tick #(
  parameter int QTR_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR_CYCLES > 2) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sccb_host_regs.sv
module sccb_host_regs
  import sccb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       busy,
  input  logic       done_evt,
  input  logic       done_rd,
  input  logic [7:0] rx_byte,
  output logic       start_evt,
  output logic       start_rd,
  output logic [7:0] status_q,
  output logic [7:0] rdata_q,
  output logic [7:0] enable_q,
  output logic [7:0] saddr_q,
  output logic [7:0] widx_q,
  output logic [7:0] wdat_q,
  output logic [7:0] ridx_q
);
  logic op_wr;
  logic code_ok;

  assign op_wr     = host_wr && (host_addr == OFS_OP) && !busy;
  assign code_ok   = (host_wdata == CODE_WRITE) || (host_wdata == CODE_READ);
  assign start_evt = op_wr && code_ok && bus_usable(enable_q);
  assign start_rd  = (host_wdata == CODE_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      saddr_q  <= '0;
      widx_q   <= '0;
      wdat_q   <= '0;
      ridx_q   <= '0;
    end else if (host_wr) begin
      case (host_addr)
        OFS_ENABLE: enable_q <= host_wdata;
        OFS_SADDR:  saddr_q  <= host_wdata;
        OFS_WIDX:   widx_q   <= host_wdata;
        OFS_WDAT:   wdat_q   <= host_wdata;
        OFS_RIDX:   ridx_q   <= host_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= ST_BUSY;
    else if (start_evt) status_q <= ST_BUSY;
    else if (op_wr) status_q <= ST_REJECT;
    else if (done_evt) status_q <= done_rd ? ST_RD_DONE : ST_WR_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (done_evt && done_rd) rdata_q <= rx_byte;
  end

  always_comb begin
    case (host_addr)
      OFS_STATUS: host_rdata = status_q;
      OFS_ENABLE: host_rdata = enable_q;
      OFS_SADDR:  host_rdata = saddr_q;
      OFS_WIDX:   host_rdata = widx_q;
      OFS_WDAT:   host_rdata = wdat_q;
      OFS_RIDX:   host_rdata = ridx_q;
      OFS_RDAT:   host_rdata = rdata_q;
      default:    host_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/sccb_line_engine.sv
module sccb_line_engine
  import sccb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_evt,
  input  logic       start_rd,
  input  logic [7:0] saddr,
  input  logic [7:0] widx,
  input  logic [7:0] wdat,
  input  logic [7:0] ridx,
  input  logic       sda_in,
  output logic       busy,
  output logic       done_evt,
  output logic       done_rd,
  output logic [7:0] rx_byte,
  output logic       scl_o,
  output logic       sda_rel_o,
  output logic       cond_phase
);
  logic             busy_q;
  logic             rd_q;
  logic [SEG_W-1:0] seg_q;
  logic [3:0]       bit_q;
  logic [1:0]       qtr_q;
  logic [7:0]       aw_q, ar_q, idx_q, dat_q, rx_q;
  logic             scl_q, sda_q, cnd_q;

  seg_kind_e  kind;
  byte_src_e  src;
  logic [7:0] cur_byte;
  logic       tx_bit;
  logic [2:0] drive;

  assign kind = plan_kind(rd_q, seg_q);
  assign src  = plan_src(rd_q, seg_q);

  always_comb begin
    case (src)
      SRC_AR:  cur_byte = ar_q;
      SRC_IDX: cur_byte = idx_q;
      SRC_DAT: cur_byte = dat_q;
      default: cur_byte = aw_q;
    endcase
    tx_bit = bit_q[3] ? 1'b1 : cur_byte[~bit_q[2:0]];
    drive  = busy_q ? line_next(kind, qtr_q, sda_q, tx_bit) : 3'b110;
  end

  assign busy       = busy_q;
  assign done_evt   = busy_q && (kind == K_END);
  assign done_rd    = done_evt && rd_q;
  assign rx_byte    = rx_q;
  assign scl_o      = scl_q;
  assign sda_rel_o  = sda_q;
  assign cond_phase = cnd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      seg_q  <= '0;
      bit_q  <= '0;
      qtr_q  <= '0;
      aw_q   <= '0;
      ar_q   <= '0;
      idx_q  <= '0;
      dat_q  <= '0;
      rx_q   <= '0;
    end else if (start_evt) begin
      busy_q <= 1'b1;
      rd_q   <= start_rd;
      seg_q  <= '0;
      bit_q  <= '0;
      qtr_q  <= '0;
      aw_q   <= addr_wr_form(saddr);
      ar_q   <= addr_rd_form(saddr);
      idx_q  <= start_rd ? ridx : widx;
      dat_q  <= wdat;
    end else if (busy_q) begin
      if (kind == K_END) begin
        busy_q <= 1'b0;
      end else if (tick) begin
        if (kind == K_RX && qtr_q == 2'd2 && !bit_q[3]) rx_q <= {rx_q[6:0], sda_in};
        if (qtr_q != 2'd3) begin
          qtr_q <= qtr_q + 2'd1;
        end else begin
          qtr_q <= 2'd0;
          if ((kind == K_TX || kind == K_RX) && bit_q != 4'd8) begin
            bit_q <= bit_q + 4'd1;
          end else begin
            bit_q <= 4'd0;
            seg_q <= seg_q + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      cnd_q <= 1'b0;
    end else begin
      scl_q <= drive[2];
      sda_q <= drive[1];
      cnd_q <= drive[0];
    end
  end
endmodule

// File: rtl/sccb_bridge.sv
module sccb_bridge
  import sccb_pkg::*;
#(
  parameter int QTR_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       scl_o,
  output logic       sda_oe_o,
  input  logic       sda_i
);
  logic       busy;
  logic       tick;
  logic       start_evt;
  logic       start_rd;
  logic       done_evt;
  logic       done_rd;
  logic       cond_phase;
  logic       sda_rel;
  logic [7:0] rx_byte;
  logic [7:0] status_q;
  logic [7:0] rdata_q;
  logic [7:0] enable_q;
  logic [7:0] saddr_q, widx_q, wdat_q, ridx_q;

  sccb_quarter_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  sccb_host_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy      (busy),
    .done_evt  (done_evt),
    .done_rd   (done_rd),
    .rx_byte   (rx_byte),
    .start_evt (start_evt),
    .start_rd  (start_rd),
    .status_q  (status_q),
    .rdata_q   (rdata_q),
    .enable_q  (enable_q),
    .saddr_q   (saddr_q),
    .widx_q    (widx_q),
    .wdat_q    (wdat_q),
    .ridx_q    (ridx_q)
  );

  sccb_line_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start_evt (start_evt),
    .start_rd  (start_rd),
    .saddr     (saddr_q),
    .widx      (widx_q),
    .wdat      (wdat_q),
    .ridx      (ridx_q),
    .sda_in    (sda_i),
    .busy      (busy),
    .done_evt  (done_evt),
    .done_rd   (done_rd),
    .rx_byte   (rx_byte),
    .scl_o     (scl_o),
    .sda_rel_o (sda_rel),
    .cond_phase(cond_phase)
  );

  assign sda_oe_o = !sda_rel;
endmodule

// File: rtl/sccb_bridge_checker.sv
module sccb_bridge_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] host_addr,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       scl_o,
  input logic       sda_oe_o,
  input logic       busy,
  input logic       done_evt,
  input logic       done_rd,
  input logic       cond_phase,
  input logic [7:0] status_q,
  input logic [7:0] rdata_q,
  input logic [7:0] enable_q
);
  logic op_cmd;
  assign op_cmd = host_wr && (host_addr == 4'd0);

  p_busy_status_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status_q == 8'h00);

  p_write_done_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !done_rd |=> status_q == 8'h04);

  p_read_done_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && done_rd |=> status_q == 8'h01);

  p_disabled_rejects_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && op_cmd && (enable_q == 8'h00 || enable_q == 8'h01) |=> !busy && status_q == 8'hFF);

  p_bad_code_rejects_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && op_cmd && host_wdata != 8'h05 && host_wdata != 8'h70 |=> !busy && status_q == 8'hFF);

  p_busy_op_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done_evt && op_cmd |=> busy && status_q == 8'h00);

  p_sda_quiet_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_o && $past(scl_o) && !cond_phase |-> $stable(sda_oe_o));

  p_idle_bus_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> scl_o && !sda_oe_o);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_evt && done_rd) |=> $stable(rdata_q));
endmodule

bind sccb_bridge sccb_bridge_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_addr (host_addr),
  .host_wr   (host_wr),
  .host_wdata(host_wdata),
  .scl_o     (scl_o),
  .sda_oe_o  (sda_oe_o),
  .busy      (busy),
  .done_evt  (done_evt),
  .done_rd   (done_rd),
  .cond_phase(cond_phase),
  .status_q  (status_q),
  .rdata_q   (rdata_q),
  .enable_q  (enable_q)
);

// File: tb/sim_sccb_bridge.sv
`timescale 1ns/1ps
module sim_sccb_bridge;
  localparam int QTR = 4;
  localparam int IT_START = 256;
  localparam int IT_STOP  = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       scl_o;
  logic       sda_oe_o;
  logic       slv_oe = 1'b0;
  wire        sda_line = ~(sda_oe_o | slv_oe);

  int nchecks = 0;
  int nfails = 0;
  int nstarts = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  int exp_q[$];
  logic [7:0] ref_mem [256];
  logic [7:0] slv_mem [256];
  logic [7:0] cur_saddr = 8'h60;

  always #10 clk = ~clk;

  sccb_bridge #(.QTR_CYCLES(QTR)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .scl_o(scl_o),
    .sda_oe_o(sda_oe_o), .sda_i(sda_line)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nfails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor side of the scoreboard: pop and compare each bus item.
  task automatic see_item(input string req, input int item);
    if (exp_q.size() == 0) chk(req, item, -1);
    else chk(req, item, exp_q.pop_front());
  endtask

  int bitn = 0;
  int bytei = 0;
  bit rdmode = 1'b0;
  bit driving = 1'b0;
  logic [7:0] shreg = 8'd0;
  logic [7:0] ptr = 8'd0;
  time t_rise = 0;

  always @(negedge sda_line) if (mon_on && scl_o === 1'b1) begin
    see_item("R2/R3 start", IT_START);
    nstarts++;
    bitn = 0; bytei = 0; rdmode = 1'b0;
  end

  always @(posedge sda_line) if (mon_on && scl_o === 1'b1) begin
    see_item("R2/R3 stop", IT_STOP);
  end

  always @(posedge scl_o) if (mon_on) begin
    if (bitn >= 1 && bitn <= 8) chk("R9 scl period", int'($time - t_rise), 4 * QTR * 20);
    t_rise = $time;
    if (bitn < 8) shreg = {shreg[6:0], sda_line};
    bitn++;
    if (bitn == 8) begin
      see_item("R2/R3 byte", int'(shreg));
      if (bytei == 0) rdmode = shreg[0];
      else if (bytei == 1 && !rdmode) ptr = shreg;
      else if (bytei == 2 && !rdmode) slv_mem[ptr] = shreg;
      bytei++;
    end
  end

  always @(negedge scl_o) if (mon_on) begin
    if (bitn == 9) begin
      bitn = 0;
      driving = rdmode && (bytei == 1);
    end
    if (driving && bitn < 8) slv_oe = ~slv_mem[ptr][7 - bitn];
    else slv_oe = 1'b0;
  end

  task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wr = 1'b0;
    #1 d = host_rdata;
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = 8'h00;
    for (int i = 0; i < 3000 && st == 8'h00; i++) hread(4'd1, st);
  endtask

  // Driver side: push the predicted bus items, then issue the command.
  task automatic do_write(input logic [7:0] idx, input logic [7:0] dat, input string req);
    logic [7:0] st;
    exp_q.push_back(IT_START);
    exp_q.push_back(int'({cur_saddr[7:1], 1'b0}));
    exp_q.push_back(int'(idx));
    exp_q.push_back(int'(dat));
    exp_q.push_back(IT_STOP);
    ref_mem[idx] = dat;
    hwrite(4'd4, idx);
    hwrite(4'd5, dat);
    hwrite(4'd0, 8'h05);
    hread(4'd1, st);
    chk("R4 busy status after write op", int'(st), 0);
    wait_done(st);
    chk({req, " write status"}, int'(st), 8'h04);
  endtask

  task automatic do_read(input logic [7:0] idx, input string req);
    logic [7:0] st;
    logic [7:0] rd;
    exp_q.push_back(IT_START);
    exp_q.push_back(int'({cur_saddr[7:1], 1'b0}));
    exp_q.push_back(int'(idx));
    exp_q.push_back(IT_STOP);
    exp_q.push_back(IT_START);
    exp_q.push_back(int'({cur_saddr[7:1], 1'b1}));
    exp_q.push_back(int'(ref_mem[idx]));
    exp_q.push_back(IT_STOP);
    hwrite(4'd8, idx);
    hwrite(4'd0, 8'h70);
    hread(4'd1, st);
    chk("R4 busy status after read op", int'(st), 0);
    wait_done(st);
    chk({req, " read status"}, int'(st), 8'h01);
    hread(4'd9, rd);
    chk("R3 read data register", int'(rd), int'(ref_mem[idx]));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nchecks++; nfails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int s0;
    for (int i = 0; i < 256; i++) begin
      ref_mem[i] = 8'(i * 7 + 3);
      slv_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R10: reset state
    hread(4'd1, v); chk("R10 status after reset", int'(v), 0);
    hread(4'd9, v); chk("R10 read data after reset", int'(v), 0);
    hread(4'd2, v); chk("R10 enable after reset", int'(v), 0);
    chk("R10 scl idle", int'(scl_o), 1);
    chk("R10 sda released", int'(sda_oe_o), 0);

    // R1: register map
    hwrite(4'd2, 8'h1E); hwrite(4'd3, 8'h60); hwrite(4'd4, 8'h11);
    hwrite(4'd5, 8'h22); hwrite(4'd8, 8'h33);
    hread(4'd2, v); chk("R1 enable readback", int'(v), 8'h1E);
    hread(4'd3, v); chk("R1 address readback", int'(v), 8'h60);
    hread(4'd4, v); chk("R1 write index readback", int'(v), 8'h11);
    hread(4'd5, v); chk("R1 write data readback", int'(v), 8'h22);
    hread(4'd8, v); chk("R1 read index readback", int'(v), 8'h33);
    hread(4'd0, v); chk("R1 op reads zero", int'(v), 0);
    hwrite(4'd9, 8'hAA); hread(4'd9, v); chk("R1 read data not writable", int'(v), 0);
    hwrite(4'd1, 8'hAA); hread(4'd1, v); chk("R1 status not writable", int'(v), 0);
    hread(4'd6, v); chk("R1 unmapped reads zero", int'(v), 0);

    // R5: bus closed by enable 0x00 and 0x01
    s0 = nstarts;
    hwrite(4'd2, 8'h00); hwrite(4'd0, 8'h05);
    hread(4'd1, v); chk("R5 enable 00 rejects", int'(v), 8'hFF);
    repeat (40) begin @(negedge clk); if (scl_o !== 1'b1 || sda_oe_o !== 1'b0) s0 = -100; end
    hwrite(4'd2, 8'h01); hwrite(4'd0, 8'h70);
    hread(4'd1, v); chk("R5 enable 01 rejects", int'(v), 8'hFF);
    repeat (40) begin @(negedge clk); if (scl_o !== 1'b1 || sda_oe_o !== 1'b0) s0 = -100; end
    chk("R5 no bus activity", nstarts, s0);

    // R6: unknown code
    hwrite(4'd2, 8'h1E);
    s0 = nstarts;
    hwrite(4'd0, 8'h33);
    hread(4'd1, v); chk("R6 unknown code rejects", int'(v), 8'hFF);
    repeat (40) @(negedge clk);
    chk("R6 no bus activity", nstarts, s0);

    // R2/R4: writes with several patterns
    do_write(8'h12, 8'hA5, "R2");
    do_write(8'h00, 8'hFF, "R2");
    do_write(8'hFF, 8'h00, "R2");

    // R3: reads of written and untouched locations
    do_read(8'h12, "R3");
    do_read(8'h40, "R3");

    // R11: a write leaves the read data register alone
    do_write(8'h41, 8'h5C, "R11");
    hread(4'd9, v); chk("R11 read data held across write", int'(v), int'(ref_mem[8'h40]));

    // R2: address bit 0 cleared on the wire
    hwrite(4'd3, 8'h43); cur_saddr = 8'h43;
    do_write(8'h07, 8'h3E, "R2 addr form");
    do_read(8'h07, "R3 addr form");
    hwrite(4'd3, 8'h60); cur_saddr = 8'h60;

    // R7: op written while busy is ignored
    s0 = nstarts;
    exp_q.push_back(IT_START); exp_q.push_back(8'h60); exp_q.push_back(8'h2A);
    exp_q.push_back(8'h99); exp_q.push_back(IT_STOP);
    ref_mem[8'h2A] = 8'h99;
    hwrite(4'd4, 8'h2A); hwrite(4'd5, 8'h99); hwrite(4'd0, 8'h05);
    repeat (20) @(negedge clk);
    hwrite(4'd0, 8'h70);
    hread(4'd1, v); chk("R7 still busy after second op", int'(v), 0);
    wait_done(v);
    chk("R7 status keeps write result", int'(v), 8'h04);
    repeat (200) @(negedge clk);
    chk("R7 only one transaction", nstarts - s0, 1);
    hread(4'd9, v); chk("R7 read data untouched", int'(v), int'(ref_mem[8'h07]));

    // R8: register edits during the transfer do not reach the bus
    exp_q.push_back(IT_START); exp_q.push_back(8'h60); exp_q.push_back(8'h21);
    exp_q.push_back(8'h3C); exp_q.push_back(IT_STOP);
    ref_mem[8'h21] = 8'h3C;
    hwrite(4'd4, 8'h21); hwrite(4'd5, 8'h3C); hwrite(4'd0, 8'h05);
    repeat (10) @(negedge clk);
    hwrite(4'd5, 8'hC3); hwrite(4'd4, 8'h99); hwrite(4'd3, 8'h42);
    wait_done(v);
    chk("R8 write status", int'(v), 8'h04);
    hread(4'd5, v); chk("R8 new data stored for later", int'(v), 8'hC3);
    hwrite(4'd3, 8'h60);
    do_read(8'h21, "R8 read back");

    repeat (100) @(negedge clk);
    chk("R2/R3 scoreboard drained", exp_q.size(), 0);
    chk("R10 bus released at end", int'({scl_o, sda_oe_o}), 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
    $finish;
  end
endmodule